// File: doc/BRIEF.md
# Target Read Prefetch Controller

This block sits in the target read path of a PCI bridge. When an external master starts a memory read, the block decides how many lines to fetch from local memory. It can fetch one demand line, or it can keep fetching lines ahead of the master for as long as the transaction lasts. The decision depends on the PCI command, on whether the address falls in a prefetchable window, on a prefetch-enable control bit and on a sticky invalidate control bit. The read buffer and the local bus protocol are outside the block. It only sees whether the buffer has room for one more line and when an issued line fetch completes.

The block is a six-state machine:

- `ST_IDLE`: waits for a transaction start.
- `ST_REQ`: raises one line-fetch request.
- `ST_WAIT`: a fetch is outstanding.
- `ST_HOLD`: prefetching is paused because the buffer is full.
- `ST_PARK`: no more fetches are allowed for the rest of the transaction.
- `ST_DRAIN`: the transaction has gone, but a fetch is still outstanding and its data will be discarded.

The transitions are:

- `ST_IDLE→ST_REQ` on a read start with frame high.
- `ST_REQ→ST_WAIT` when the request is issued.
- `ST_REQ→ST_IDLE` when frame is low.
- `ST_REQ→ST_PARK` when an invalidate edge cancels the request.
- `ST_WAIT→ST_REQ` on completion with prefetch active and buffer room.
- `ST_WAIT→ST_HOLD` on completion with prefetch active and no room.
- `ST_WAIT→ST_PARK` on completion when prefetch is not active.
- `ST_WAIT→ST_IDLE` on a completion that is dropped.
- `ST_WAIT→ST_DRAIN` when frame drops or the invalidate bit rises with the fetch still open.
- `ST_HOLD→ST_REQ` when room returns.
- `ST_HOLD→ST_PARK` when invalidated.
- `ST_HOLD→ST_IDLE` and `ST_PARK→ST_IDLE` when frame drops.
- `ST_DRAIN→ST_IDLE` on completion.

A rising edge of the invalidate bit also produces a one-cycle purge strobe for the buffer. If prefetched data is being returned to the bus at that moment, the block also asks the target to disconnect.

Top module: `pfc_top`

## Requirements
- R1: A line fetch starts only when `start` is high with `frame` high in idle, and `cmd` is a memory read (0x6), memory read line (0xE) or memory read multiple (0xC). Any other code gives no `line_req`. After reset all outputs are low.
- R2: For 0x6 or 0xE with `pf_en`=1 and `pf_win`=1 and the invalidate bit clear, the block keeps requesting further lines while `frame` and `buf_room` are high.
- R3: `pf_en` has no effect when `pf_win`=0: a 0x6 or 0xE read then gets exactly one line.
- R4: Command 0xC prefetches multiple lines even when `pf_en`=0 and `pf_win`=0.
- R5: A 0x6 or 0xE read without `pf_en` fetches exactly one line per transaction.
- R6: While prefetching, no new `line_req` is raised while `buf_room` is low. Requests resume after it returns.
- R7: `line_req` is never high while `frame` is low.
- R8: A fetch still outstanding when `frame` falls completes with `fetch_drop` high in the cycle of its `fetch_done`.
- R9: A rising edge of `inval_bit` gives `inval_pulse` high for exactly one cycle.
- R10: `disc_req` is high in the cycle of that rising edge exactly when `rd_xfer` and `frame` are high.
- R11: A fetch outstanding when `inval_bit` rises completes with `fetch_drop` high, and no further `line_req` follows in that transaction.
- R12: While `inval_bit` stays set, no transaction gets more than one line, including 0xC.
- R13: Each `line_req` is a one-cycle pulse. The next one comes only after a `fetch_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Address phase strobe; `cmd` and window flag are valid |
| cmd | input | 4 | PCI command code |
| pf_win | input | 1 | Address hits a prefetchable window |
| pf_en | input | 1 | Prefetch enable control bit |
| inval_bit | input | 1 | Sticky invalidate-and-disable control bit |
| frame | input | 1 | Transaction in progress (active high) |
| buf_room | input | 1 | Read buffer can take another line |
| rd_xfer | input | 1 | Prefetched data is being returned to the bus |
| fetch_done | input | 1 | Outstanding local line fetch completes |
| line_req | output | 1 | Request one line from local memory |
| fetch_drop | output | 1 | Completing fetch's data must be discarded |
| inval_pulse | output | 1 | Purge all held prefetched data |
| disc_req | output | 1 | Ask the target to disconnect |

## Verification
Directed transactions run each read command under each enable and window combination, with the buffer kept free. The number of lines fetched separates single-line from prefetch behaviour and shows that the 0xC override works. Further directed cases hold `buf_room` low, drop `frame` while a fetch is open, and raise the invalidate bit with and without data returning. These separate pausing, draining and disconnecting. A long seeded random run mixes starts, commands, frame lengths, buffer pressure and invalidate toggles. Every output is compared each cycle against a bench model built from the requirements.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_MR  = 4'h6;
    localparam logic [CMD_W-1:0] CMD_MRL = 4'hE;
    localparam logic [CMD_W-1:0] CMD_MRM = 4'hC;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_PARK  = 3'd4,
        ST_DRAIN = 3'd5
    } pf_state_t;
endpackage

// File: rtl/pfc_cmd_decode.sv
module pfc_cmd_decode
    import pfc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             pf_en,
    input  logic             pf_win,
    input  logic             inval_bit,
    output logic             is_read,
    output logic             want_multi
);
    logic is_mrm;

    always_comb begin
        is_mrm     = (cmd == CMD_MRM);
        is_read    = (cmd == CMD_MR) || (cmd == CMD_MRL) || is_mrm;
        want_multi = is_read && !inval_bit && (is_mrm || (pf_en && pf_win));
    end
endmodule

// File: rtl/pfc_inval_track.sv
module pfc_inval_track (
    input  logic clk,
    input  logic rst_n,
    input  logic inval_bit,
    input  logic frame,
    input  logic rd_xfer,
    output logic inval_rise,
    output logic disc_req
);
    logic inval_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inval_q <= 1'b0;
        else        inval_q <= inval_bit;
    end

    always_comb begin
        inval_rise = inval_bit && !inval_q;
        disc_req   = inval_rise && rd_xfer && frame;
    end

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        inval_rise |=> !inval_rise);
    a_r10_disc_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |-> (rd_xfer && frame && inval_bit));
endmodule

// File: rtl/pfc_top.sv
module pfc_top
    import pfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             pf_win,
    input  logic             pf_en,
    input  logic             inval_bit,
    input  logic             frame,
    input  logic             buf_room,
    input  logic             rd_xfer,
    input  logic             fetch_done,
    output logic             line_req,
    output logic             fetch_drop,
    output logic             inval_pulse,
    output logic             disc_req
);
    pf_state_t state, state_nx;
    logic      multi_q, multi_nx;
    logic      is_read, want_multi, inval_rise;
    logic      eff_multi, kill;

    pfc_cmd_decode u_dec (
        .cmd        (cmd),
        .pf_en      (pf_en),
        .pf_win     (pf_win),
        .inval_bit  (inval_bit),
        .is_read    (is_read),
        .want_multi (want_multi)
    );

    pfc_inval_track u_inv (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval_bit  (inval_bit),
        .frame      (frame),
        .rd_xfer    (rd_xfer),
        .inval_rise (inval_rise),
        .disc_req   (disc_req)
    );

    assign eff_multi = multi_q && !inval_bit;
    assign kill      = !frame || inval_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            multi_q <= 1'b0;
        end else begin
            state   <= state_nx;
            multi_q <= multi_nx;
        end
    end

    always_comb begin
        state_nx = state;
        multi_nx = multi_q;
        unique case (state)
            ST_IDLE: begin
                if (start && frame && is_read) begin
                    state_nx = ST_REQ;
                    multi_nx = want_multi;
                end
            end
            ST_REQ: begin
                if (!frame)          state_nx = ST_IDLE;
                else if (inval_rise) state_nx = ST_PARK;
                else                 state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (kill)            state_nx = fetch_done ? ST_IDLE : ST_DRAIN;
                else if (fetch_done) begin
                    if (!eff_multi)    state_nx = ST_PARK;
                    else if (buf_room) state_nx = ST_REQ;
                    else               state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!frame)          state_nx = ST_IDLE;
                else if (!eff_multi) state_nx = ST_PARK;
                else if (buf_room)   state_nx = ST_REQ;
            end
            ST_PARK: begin
                if (!frame) state_nx = ST_IDLE;
            end
            ST_DRAIN: begin
                if (fetch_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        line_req    = (state == ST_REQ) && frame && !inval_rise;
        fetch_drop  = fetch_done && ((state == ST_DRAIN) || ((state == ST_WAIT) && kill));
        inval_pulse = inval_rise;
    end

    a_r7_req_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> frame);
    a_r13_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |=> !line_req);
    a_r8_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_drop |-> fetch_done);
    a_r6_hold_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !line_req);
    a_r12_no_multi_when_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_bit && state == ST_WAIT && fetch_done) |=> !line_req);
endmodule

// File: tb/pfc_top_tb_top.sv
module pfc_top_tb_top;
    localparam int ST_I = 0, ST_R = 1, ST_W = 2, ST_H = 3, ST_P = 4, ST_D = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, pf_win = 0, pf_en = 0, inval_bit = 0, frame = 0;
    logic buf_room = 1, rd_xfer = 0, fetch_done = 0;
    logic [3:0] cmd = 4'h0;
    logic line_req, fetch_drop, inval_pulse, disc_req;

    int total = 0, bad = 0;
    int m_st = ST_I;
    bit m_multi = 0, m_invq = 0, auto_done = 1;
    int nreq = 0, ndrop = 0, ndisc = 0, npulse = 0;

    always #4 clk = ~clk;

    pfc_top dut_i (.clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .pf_win(pf_win),
        .pf_en(pf_en), .inval_bit(inval_bit), .frame(frame), .buf_room(buf_room),
        .rd_xfer(rd_xfer), .fetch_done(fetch_done), .line_req(line_req),
        .fetch_drop(fetch_drop), .inval_pulse(inval_pulse), .disc_req(disc_req));

    function automatic bit is_rd(logic [3:0] c);
        return c == 4'h6 || c == 4'hE || c == 4'hC;
    endfunction

    function automatic bit multi_of(logic [3:0] c, bit en, bit w, bit inv);
        return is_rd(c) && !inv && (c == 4'hC || (en && w));
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        bit rise, kill, e_line, e_drop;
        @(negedge clk);
        if (auto_done) fetch_done = (m_st == ST_W || m_st == ST_D);
        #1;
        rise   = inval_bit && !m_invq;
        kill   = !frame || rise;
        e_line = (m_st == ST_R) && frame && !rise;
        e_drop = fetch_done && (m_st == ST_D || (m_st == ST_W && kill));
        chk("R2 R13 line_req", line_req, e_line);
        chk("R8 R11 fetch_drop", fetch_drop, e_drop);
        chk("R9 inval_pulse", inval_pulse, rise);
        chk("R10 disc_req", disc_req, rise && rd_xfer && frame);
        nreq += int'(line_req); ndrop += int'(fetch_drop);
        ndisc += int'(disc_req); npulse += int'(inval_pulse);
        @(posedge clk); #1;
        case (m_st)
            ST_I: if (start && frame && is_rd(cmd)) begin
                m_st = ST_R; m_multi = multi_of(cmd, pf_en, pf_win, inval_bit);
            end
            ST_R: m_st = !frame ? ST_I : (rise ? ST_P : ST_W);
            ST_W: if (kill) m_st = fetch_done ? ST_I : ST_D;
                  else if (fetch_done)
                      m_st = !(m_multi && !inval_bit) ? ST_P : (buf_room ? ST_R : ST_H);
            ST_H: if (!frame) m_st = ST_I;
                  else if (!(m_multi && !inval_bit)) m_st = ST_P;
                  else if (buf_room) m_st = ST_R;
            ST_P: if (!frame) m_st = ST_I;
            ST_D: if (fetch_done) m_st = ST_I;
            default: m_st = ST_I;
        endcase
        m_invq = inval_bit;
    endtask

    task automatic txn(logic [3:0] c, bit en, bit w, int len, output int n);
        nreq = 0;
        cmd = c; pf_en = en; pf_win = w; start = 1; frame = 1;
        step(); start = 0;
        for (int i = 1; i < len; i++) step();
        frame = 0;
        repeat (3) step();
        n = nreq;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset line_req", line_req, 1'b0);
        chk("R1 reset fetch_drop", fetch_drop, 1'b0);
        chk("R1 reset disc_req", disc_req, 1'b0);
        rst_n = 1;
        repeat (2) step();

        txn(4'h6, 1, 1, 12, n); chk("R2 MR prefetch lines>1", n > 1, 1'b1);
        txn(4'hE, 1, 1, 12, n); chk("R2 MRL prefetch lines>1", n > 1, 1'b1);
        txn(4'h6, 1, 0, 12, n); chk_int("R3 window miss one line", n, 1);
        txn(4'hC, 0, 0, 12, n); chk("R4 MRM forced prefetch", n > 1, 1'b1);
        txn(4'hE, 0, 1, 12, n); chk_int("R5 no enable one line", n, 1);
        txn(4'h7, 1, 1, 12, n); chk_int("R1 write command no fetch", n, 0);
        txn(4'h2, 1, 1, 12, n); chk_int("R1 io read no fetch", n, 0);

        // R6: buffer full after first line
        nreq = 0; buf_room = 0; cmd = 4'hC; start = 1; frame = 1;
        step(); start = 0;
        repeat (8) step();
        chk_int("R6 held while full", nreq, 1);
        buf_room = 1;
        repeat (4) step();
        chk("R6 resumes with room", nreq > 1, 1'b1);
        frame = 0; repeat (3) step();

        // R7 R8: frame drops with fetch open
        auto_done = 0; fetch_done = 0; ndrop = 0; nreq = 0;
        cmd = 4'h6; pf_en = 1; pf_win = 1; start = 1; frame = 1;
        step(); start = 0;
        step(); step();
        frame = 0; step(); step();
        fetch_done = 1; step(); fetch_done = 0;
        chk_int("R8 outstanding fetch dropped", ndrop, 1);
        chk_int("R7 single request before frame drop", nreq, 1);
        auto_done = 1; repeat (2) step();

        // R9 R10 R11: invalidate mid prefetch with data returning
        auto_done = 0; ndrop = 0; ndisc = 0; npulse = 0; nreq = 0;
        cmd = 4'hC; start = 1; frame = 1; rd_xfer = 1;
        step(); start = 0; step();
        inval_bit = 1; step(); step(); step();
        fetch_done = 1; step(); fetch_done = 0;
        repeat (3) step();
        chk_int("R9 one purge strobe", npulse, 1);
        chk_int("R10 disconnect raised", ndisc, 1);
        chk_int("R11 in-flight data dropped", ndrop, 1);
        chk_int("R11 no request after invalidate", nreq, 1);
        frame = 0; rd_xfer = 0; auto_done = 1; repeat (2) step();

        // R12: invalidate held, MRM only one line
        txn(4'hC, 1, 1, 12, n); chk_int("R12 sticky invalidate one line", n, 1);
        inval_bit = 0; step();
        // R10: edge without data return gives no disconnect
        ndisc = 0; frame = 1; inval_bit = 1; step(); inval_bit = 0; frame = 0; step();
        chk_int("R10 no disconnect without xfer", ndisc, 0);

        for (int k = 0; k < 4000; k++) begin
            int r = $urandom % 5;
            start    = ($urandom % 6) == 0;
            cmd      = (r == 0) ? 4'h6 : (r == 1) ? 4'hE : (r == 2) ? 4'hC : (r == 3) ? 4'h7 : 4'h2;
            pf_en    = $urandom % 2;
            pf_win   = $urandom % 2;
            if (($urandom % 8) == 0) frame = ~frame;
            buf_room = ($urandom % 4) != 0;
            rd_xfer  = $urandom % 2;
            if (($urandom % 40) == 0) inval_bit = ~inval_bit;
            auto_done = 0;
            fetch_done = (m_st == ST_W || m_st == ST_D) ? ($urandom % 2) : (($urandom % 20) == 0);
            step();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule